// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Generator

This block sits in an SDRAM command path. It watches the command lines for a mode-register-set command and keeps the mode in a register. The mode is taken from the low address bits and holds the burst length, the burst order, the CAS latency and a write-burst option. Illegal length or latency codes are rejected: the stored mode stays as it was and an error pulse is raised.

When a read or write burst is launched, the block latches the starting column from the address bus. It then emits one column address per clock until the burst is done, and marks the final beat. Bursts wrap inside their own aligned boundary, in either sequential or interleaved order. Writes can be restricted to a single beat while reads keep the programmed length. Each burst keeps the settings that were in force when it began. A new launch cuts short any burst in flight.

Top module: `sdr_burst_agen`

## Requirements
- R1: A mode-register-set command writes the mode register. It is recognised when cs_n, ras_n, cas_n and we_n are all low on a rising edge and bank is all zeros. Any other command, or a nonzero bank, leaves the mode unchanged.
- R2: addr[2:0] selects the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8.
- R3: addr[3]=0 selects sequential order and addr[3]=1 selects interleaved order. For beat k of a burst of length BL starting at column S, the low log2(BL) column bits are (S+k) mod BL in sequential order and S xor k in interleaved order. All higher column bits stay equal to those of S.
- R4: addr[6:4] sets the CAS latency, shown on cas_lat: 010 gives 2 and 011 gives 3.
- R5: With addr[9]=1, write bursts last one beat and reads keep the programmed length. With addr[9]=0, writes use the full length.
- R6: A burst-length code of 100 to 111, or a latency code other than 010 and 011, leaves the whole mode unchanged. It raises mode_err for exactly the one cycle that follows the command.
- R7: burst_start is sampled on a rising edge, with the start column on addr[10:0] and the direction on burst_write (1 = write). col_valid is high and col_addr holds the start column in the following cycle. One beat follows per cycle after that.
- R8: last_beat is high only on a burst's final beat. If no new burst is launched, col_valid is low in the cycle after the final beat.
- R9: A burst uses the mode that was stored when it was launched. A mode change during the burst does not alter its length or order.
- R10: burst_start during an active burst abandons the old burst with no last_beat. The new burst's first beat follows in the next cycle.
- R11: After reset, col_valid, last_beat and mode_err are low. The mode is burst length 1, sequential order, CAS latency 2, with full write bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | BANK_W (2) | Bank select; must be zero for a mode write |
| addr | input | ADDR_W (13) | Mode bits during a mode write; start column during a launch |
| burst_start | input | 1 | Launch a burst this cycle |
| burst_write | input | 1 | 1 = write burst, 0 = read burst |
| col_addr | output | COL_W (11) | Current column address |
| col_valid | output | 1 | col_addr holds a burst beat |
| last_beat | output | 1 | Current beat is the burst's last |
| cas_lat | output | 3 | Stored CAS latency |
| mode_err | output | 1 | One-cycle pulse after a rejected mode write |

## Verification
A mode write changes cas_lat one edge after it is sampled. A rejected mode write raises mode_err over that same interval. The first column of a burst appears one edge after burst_start, and each later beat one edge after the previous one. The bench therefore drives inputs on the falling edge and reads results on the next falling edge, before the inputs change. It compares every beat against a column computed from the requirement formula. It also looks one cycle past each final beat to confirm col_valid has dropped.

// File: rtl/sdr_agen_pkg.sv
package sdr_agen_pkg;

   // Widest burst is 8 beats: three low column bits take part in wrapping.
   localparam int BL_LOG_MAX = 3;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_ILV = 1'b1
   } burst_order_e;

   typedef struct packed {
      logic [1:0]   len_code;   // 0..3 -> 1,2,4,8 beats
      burst_order_e order;
      logic [2:0]   cl;
      logic         wr_single;
   } sdr_mode_t;

   localparam sdr_mode_t MODE_AFTER_RESET = '{
      len_code : 2'd0,
      order    : ORD_SEQ,
      cl       : 3'd2,
      wr_single: 1'b0
   };

endpackage

// File: rtl/sdr_agen_mode_dec.sv
module sdr_agen_mode_dec
   import sdr_agen_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BANK_W-1:0] bank,
   input  logic [ADDR_W-1:0] addr,
   output sdr_mode_t         mode_o,
   output logic              err_o
);

   localparam logic [2:0] CL_TWO   = 3'b010;
   localparam logic [2:0] CL_THREE = 3'b011;

   logic      cmd_hit;
   logic      len_ok;
   logic      cl_ok;
   sdr_mode_t mode_q;
   sdr_mode_t mode_new;
   logic      err_q;

   assign cmd_hit = !cs_n && !ras_n && !cas_n && !we_n && (bank == '0);
   assign len_ok  = (addr[2] == 1'b0);
   assign cl_ok   = (addr[6:4] == CL_TWO) || (addr[6:4] == CL_THREE);

   always_comb begin
      mode_new.len_code  = addr[1:0];
      mode_new.order     = burst_order_e'(addr[3]);
      mode_new.cl        = addr[6:4];
      mode_new.wr_single = addr[9];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_AFTER_RESET;
         err_q  <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (cmd_hit) begin
            if (len_ok && cl_ok) begin
               mode_q <= mode_new;
            end else begin
               err_q <= 1'b1;
            end
         end
      end
   end

   // Bits not carrying mode information.
   logic addr_unused_ok;
   assign addr_unused_ok = ^{addr[8:7], addr[ADDR_W-1:10]};

   assign mode_o = mode_q;
   assign err_o  = err_q;

endmodule

// File: rtl/sdr_agen_col_seq.sv
module sdr_agen_col_seq
   import sdr_agen_pkg::*;
#(
   parameter int COL_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             is_write_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [1:0]       len_code_i,
   input  burst_order_e     order_i,
   input  logic             wr_single_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);

   localparam int LW = BL_LOG_MAX;

   logic [LW-1:0]    len_req;
   logic             act_q;
   logic [LW-1:0]    cnt_q;
   logic [LW-1:0]    len_q;      // beats minus one; also the wrap mask
   logic             ilv_q;
   logic [COL_W-1:0] start_q;
   logic [LW-1:0]    low_seq;
   logic [LW-1:0]    low_ilv;
   logic [LW-1:0]    low_sel;

   always_comb begin
      unique case (len_code_i)
         2'd0:    len_req = LW'(0);
         2'd1:    len_req = LW'(1);
         2'd2:    len_req = LW'(3);
         default: len_req = LW'(7);
      endcase
      if (is_write_i && wr_single_i) begin
         len_req = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         cnt_q   <= '0;
         len_q   <= '0;
         ilv_q   <= 1'b0;
         start_q <= '0;
      end else if (start_i) begin
         act_q   <= 1'b1;
         cnt_q   <= '0;
         len_q   <= len_req;
         ilv_q   <= (order_i == ORD_ILV);
         start_q <= start_col_i;
      end else if (act_q) begin
         if (cnt_q == len_q) begin
            act_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + LW'(1);
         end
      end
   end

   assign low_seq = start_q[LW-1:0] + cnt_q;
   assign low_ilv = start_q[LW-1:0] ^ cnt_q;
   assign low_sel = ilv_q ? low_ilv : low_seq;

   for (genvar i = 0; i < COL_W; i++) begin : g_col
      if (i < LW) begin : g_wrap
         assign col_o[i] = len_q[i] ? low_sel[i] : start_q[i];
      end else begin : g_hold
         assign col_o[i] = start_q[i];
      end
   end

   assign valid_o = act_q;
   assign last_o  = act_q && (cnt_q == len_q);

endmodule

// File: rtl/sdr_burst_agen.sv
module sdr_burst_agen
   import sdr_agen_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BANK_W = 2,
   parameter int COL_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BANK_W-1:0] bank,
   input  logic [ADDR_W-1:0] addr,
   input  logic              burst_start,
   input  logic              burst_write,
   output logic [COL_W-1:0]  col_addr,
   output logic              col_valid,
   output logic              last_beat,
   output logic [2:0]        cas_lat,
   output logic              mode_err
);

   if (ADDR_W < 11) begin : g_bad_addr
      $error("ADDR_W must cover the mode bits and more");
   end
   if (COL_W <= BL_LOG_MAX || COL_W > ADDR_W) begin : g_bad_col
      $error("COL_W must exceed the wrap width and fit in ADDR_W");
   end
   if (BANK_W < 1) begin : g_bad_bank
      $error("BANK_W must be at least 1");
   end

   sdr_mode_t mode;

   sdr_agen_mode_dec #(
      .ADDR_W(ADDR_W),
      .BANK_W(BANK_W)
   ) u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .bank  (bank),
      .addr  (addr),
      .mode_o(mode),
      .err_o (mode_err)
   );

   sdr_agen_col_seq #(
      .COL_W(COL_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (burst_start),
      .is_write_i (burst_write),
      .start_col_i(addr[COL_W-1:0]),
      .len_code_i (mode.len_code),
      .order_i    (mode.order),
      .wr_single_i(mode.wr_single),
      .col_o      (col_addr),
      .valid_o    (col_valid),
      .last_o     (last_beat)
   );

   assign cas_lat = mode.cl;

endmodule

// File: rtl/sdr_burst_agen_chk.sv
module sdr_burst_agen_chk #(
   parameter int ADDR_W = 13,
   parameter int BANK_W = 2,
   parameter int COL_W  = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [BANK_W-1:0] bank,
   input logic [ADDR_W-1:0] addr,
   input logic              burst_start,
   input logic [COL_W-1:0]  col_addr,
   input logic              col_valid,
   input logic              last_beat,
   input logic [2:0]        cas_lat,
   input logic              mode_err
);

   AST_ERR_AFTER_MODE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> $past(!cs_n && !ras_n && !cas_n && !we_n && bank == '0)); // R6

   AST_ERR_KEEPS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> $stable(cas_lat)); // R6

   AST_LATENCY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_lat == 3'd2) || (cas_lat == 3'd3)); // R4

   AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      burst_start |=> (col_valid && col_addr == $past(addr[COL_W-1:0]))); // R7

   AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && $past(col_valid) && !$past(burst_start))
         |-> $stable(col_addr[COL_W-1:3])); // R3

   AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |-> col_valid); // R8

   AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (last_beat && !burst_start) |=> !col_valid); // R8

endmodule

bind sdr_burst_agen sdr_burst_agen_chk #(
   .ADDR_W(ADDR_W),
   .BANK_W(BANK_W),
   .COL_W (COL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .ras_n      (ras_n),
   .cas_n      (cas_n),
   .we_n       (we_n),
   .bank       (bank),
   .addr       (addr),
   .burst_start(burst_start),
   .col_addr   (col_addr),
   .col_valid  (col_valid),
   .last_beat  (last_beat),
   .cas_lat    (cas_lat),
   .mode_err   (mode_err)
);

// File: tb/tb_sdr_burst_agen.sv
`timescale 1ns/1ps
module tb_sdr_burst_agen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  bank = '0;
   logic [12:0] addr = '0;
   logic        burst_start = 1'b0;
   logic        burst_write = 1'b0;
   logic [10:0] col_addr;
   logic        col_valid;
   logic        last_beat;
   logic [2:0]  cas_lat;
   logic        mode_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sdr_burst_agen dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .bank(bank), .addr(addr), .burst_start(burst_start),
      .burst_write(burst_write), .col_addr(col_addr), .col_valid(col_valid),
      .last_beat(last_beat), .cas_lat(cas_lat), .mode_err(mode_err)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: %s got %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Mode word: a9 write-single, cl latency code, ilv order, lc length code.
   function automatic logic [12:0] mword(input bit a9, input logic [2:0] cl,
                                         input bit ilv, input logic [2:0] lc);
      return {3'b000, a9, 2'b00, cl, ilv, lc};
   endfunction

   function automatic logic [10:0] exp_col(input logic [10:0] s, input int k,
                                           input int bl, input bit ilv);
      logic [10:0] m;
      logic [10:0] lo;
      m  = 11'(bl - 1);
      lo = ilv ? ((s ^ 11'(k)) & m) : ((s + 11'(k)) & m);
      return (s & ~m) | lo;
   endfunction

   task automatic cmd(input bit c, input bit r, input bit ca, input bit w,
                      input logic [1:0] b, input logic [12:0] a);
      @(negedge clk);
      cs_n = c; ras_n = r; cas_n = ca; we_n = w; bank = b; addr = a;
      @(negedge clk);
      cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; bank = '0;
   endtask

   task automatic set_mode(input logic [12:0] a);
      cmd(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, a);
   endtask

   // Launch a burst and check every beat plus the idle cycle after it.
   task automatic burst(input string req, input logic [10:0] s, input bit wr,
                        input int beats, input int bl, input bit ilv);
      @(negedge clk);
      burst_start = 1'b1; burst_write = wr; addr = {2'b00, s};
      @(negedge clk);
      burst_start = 1'b0; burst_write = 1'b0;
      for (int k = 0; k < beats; k++) begin
         chk(req, $sformatf("valid beat %0d", k), 32'(col_valid), 32'd1);
         chk(req, $sformatf("col beat %0d", k), 32'(col_addr), 32'(exp_col(s, k, bl, ilv)));
         chk(req, $sformatf("last beat %0d", k), 32'(last_beat), 32'(k == beats - 1));
         @(negedge clk);
      end
      chk(req, "valid after burst", 32'(col_valid), 32'd0);
   endtask

   task automatic t_reset;
      chk("R11", "col_valid", 32'(col_valid), 32'd0);
      chk("R11", "last_beat", 32'(last_beat), 32'd0);
      chk("R11", "mode_err", 32'(mode_err), 32'd0);
      chk("R11", "cas_lat", 32'(cas_lat), 32'd2);
      burst("R11", 11'h2A7, 1'b1, 1, 1, 1'b0);
   endtask

   task automatic t_sequential;
      set_mode(mword(1'b0, 3'b011, 1'b0, 3'b010));
      chk("R4", "cas_lat 3", 32'(cas_lat), 32'd3);
      burst("R2 R3 R7 R8", 11'h13D, 1'b0, 4, 4, 1'b0);
      set_mode(mword(1'b0, 3'b010, 1'b0, 3'b011));
      chk("R4", "cas_lat 2", 32'(cas_lat), 32'd2);
      burst("R2 R3", 11'h006, 1'b0, 8, 8, 1'b0);
      set_mode(mword(1'b0, 3'b010, 1'b0, 3'b000));
      burst("R2", 11'h555, 1'b0, 1, 1, 1'b0);
   endtask

   task automatic t_interleaved;
      set_mode(mword(1'b0, 3'b010, 1'b1, 3'b011));
      burst("R3", 11'h7F5, 1'b0, 8, 8, 1'b1);
      set_mode(mword(1'b0, 3'b011, 1'b1, 3'b001));
      burst("R2 R3", 11'h003, 1'b0, 2, 2, 1'b1);
      set_mode(mword(1'b0, 3'b011, 1'b1, 3'b010));
      burst("R3", 11'h40E, 1'b0, 4, 4, 1'b1);
   endtask

   task automatic t_write_single;
      set_mode(mword(1'b1, 3'b011, 1'b0, 3'b010));
      burst("R5", 11'h0A1, 1'b1, 1, 4, 1'b0);
      burst("R5", 11'h0A1, 1'b0, 4, 4, 1'b0);
      set_mode(mword(1'b0, 3'b011, 1'b0, 3'b010));
      burst("R5", 11'h0A1, 1'b1, 4, 4, 1'b0);
   endtask

   task automatic t_reserved;
      set_mode(mword(1'b0, 3'b011, 1'b0, 3'b010));
      set_mode(mword(1'b0, 3'b010, 1'b0, 3'b100));
      chk("R6", "err on bad length", 32'(mode_err), 32'd1);
      chk("R6", "cas_lat kept", 32'(cas_lat), 32'd3);
      @(negedge clk);
      chk("R6", "err one cycle", 32'(mode_err), 32'd0);
      burst("R6", 11'h231, 1'b0, 4, 4, 1'b0);
      set_mode(mword(1'b0, 3'b001, 1'b1, 3'b011));
      chk("R6", "err on bad latency", 32'(mode_err), 32'd1);
      burst("R6", 11'h231, 1'b0, 4, 4, 1'b0);
      set_mode(mword(1'b0, 3'b100, 1'b0, 3'b000));
      chk("R6", "err on latency 4", 32'(mode_err), 32'd1);
      chk("R6", "cas_lat after bad", 32'(cas_lat), 32'd3);
   endtask

   task automatic t_ignored;
      // Mode currently BL4, sequential, CL3.
      cmd(1'b0, 1'b0, 1'b0, 1'b0, 2'b01, mword(1'b0, 3'b010, 1'b1, 3'b011));
      chk("R1", "nonzero bank no err", 32'(mode_err), 32'd0);
      chk("R1", "nonzero bank cas_lat", 32'(cas_lat), 32'd3);
      cmd(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, mword(1'b0, 3'b010, 1'b1, 3'b011));
      chk("R1", "other command cas_lat", 32'(cas_lat), 32'd3);
      cmd(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, mword(1'b0, 3'b010, 1'b1, 3'b011));
      chk("R1", "deselected cas_lat", 32'(cas_lat), 32'd3);
      burst("R1", 11'h312, 1'b0, 4, 4, 1'b0);
   endtask

   task automatic t_mode_mid_burst;
      set_mode(mword(1'b0, 3'b011, 1'b0, 3'b010));
      @(negedge clk);
      burst_start = 1'b1; addr = 13'h010;
      @(negedge clk);
      burst_start = 1'b0;
      chk("R9", "col beat 0", 32'(col_addr), 32'h010);
      cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; bank = '0;
      addr = mword(1'b0, 3'b010, 1'b1, 3'b011);
      @(negedge clk);
      cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
      chk("R9", "new latency applied", 32'(cas_lat), 32'd2);
      for (int k = 1; k < 4; k++) begin
         chk("R9", $sformatf("col beat %0d", k), 32'(col_addr), 32'(exp_col(11'h010, k, 4, 1'b0)));
         chk("R9", $sformatf("last beat %0d", k), 32'(last_beat), 32'(k == 3));
         @(negedge clk);
      end
      chk("R9", "valid after old burst", 32'(col_valid), 32'd0);
      burst("R9", 11'h010, 1'b0, 8, 8, 1'b1);
   endtask

   task automatic t_restart;
      set_mode(mword(1'b0, 3'b011, 1'b0, 3'b011));
      @(negedge clk);
      burst_start = 1'b1; addr = 13'h020;
      @(negedge clk);
      burst_start = 1'b0;
      chk("R10", "old beat 0", 32'(col_addr), 32'h020);
      @(negedge clk);
      chk("R10", "old beat 1", 32'(col_addr), 32'h021);
      chk("R10", "old burst not last", 32'(last_beat), 32'd0);
      burst_start = 1'b1; addr = 13'h105;
      @(negedge clk);
      burst_start = 1'b0;
      for (int k = 0; k < 8; k++) begin
         chk("R10", $sformatf("new col %0d", k), 32'(col_addr), 32'(exp_col(11'h105, k, 8, 1'b0)));
         chk("R10", $sformatf("new last %0d", k), 32'(last_beat), 32'(k == 7));
         @(negedge clk);
      end
      chk("R10", "valid after new burst", 32'(col_valid), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sequential();
      t_interleaved();
      t_write_single();
      t_reserved();
      t_ignored();
      t_mode_mid_burst();
      t_restart();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule